// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a chip into one system reset and shares a single open-drain reset pad in both directions. The internal requests are power-on/brown-out, independent watchdog, window watchdog or software, debug-port and illegal-opcode. Any internal request starts a pulse timer, and the block pulls the pad low for as long as the timer runs. The pad level is read back through a two-flop synchroniser and a glitch filter. An externally pulled pad therefore resets the chip, and an internally driven pulse shows up on the board as well.

A sticky cause register keeps one bit per source across every reset except power-on. Software clears it bit by bit with write-one-to-clear. Software can also switch the pad to general-purpose use. The pad is then neither driven nor observed, and only a power-on request returns it to reset duty.

Top module: `reset_merge`

## Requirements
- R1: The pad output is a pull-low enable only (`pad_pull_low`). In pad-reset mode, any internal request makes it 1 at the next clock edge. An external low level alone never sets it.
- R2: The pad input passes a two-flop synchroniser and then needs FILT_LEN consecutive low samples before it counts as an external reset. With FILT_LEN=4, a pad low for 3 clock edges causes no reset. A pad that goes low just after edge E raises `sys_rst` after edge E+6. An external reset sets cause bit 1.
- R3: After the last edge on which an internal request is sampled high, `pad_pull_low` stays 1 for exactly PULSE_CYC clock edges.
- R4: An internal request during an active pulse restarts the count, so the pad is released PULSE_CYC edges after the newest request.
- R5: `sys_rst` is 1 as soon as any internal request is high, before any clock edge.
- R6: `sys_rst` is released only at a clock edge, after the pulse has ended and the filtered pad reads high. In pad-reset mode it falls 3 edges after the pad is released (PULSE_CYC+3 edges after the last request edge). In general-purpose mode it falls PULSE_CYC edges after the last request edge.
- R7: `sys_rst` stays 1 for as long as `src_por` is held, however long that is.
- R8: A write with `gpio_wr`=1 loads `gpio_val` into `gpio_mode`. While `gpio_mode` is 1, the pad level is ignored and `pad_pull_low` stays 0. Only `src_por` clears `gpio_mode`; other resets leave it unchanged.
- R9: `rst_cause` bits are power-on = 0, external pad = 1, independent watchdog = 2, window watchdog/software = 3, debug port = 4, illegal opcode = 5. Bits are sticky across non-power-on resets. `src_por` sets the register to 6'b000001.
- R10: Each 1 in `cause_clr` clears the matching `rst_cause` bit at the next edge. A source that is active in the same cycle wins over the clear.
- R11: A pad low caused by the block's own pulse does not set the external-pad cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| src_por | input | 1 | Power-on/brown-out request, also the block's synchronous reset |
| src_iwdg | input | 1 | Independent watchdog request |
| src_wwdg | input | 1 | Window watchdog or software request |
| src_dbg | input | 1 | Debug-port reset request |
| src_badop | input | 1 | Illegal opcode request |
| pad_in | input | 1 | Asynchronous level of the reset pad |
| gpio_wr | input | 1 | Write strobe for the pad mode bit |
| gpio_val | input | 1 | Value written to the pad mode bit |
| cause_clr | input | 6 | Write-one-to-clear mask for the cause register |
| pad_pull_low | output | 1 | Open-drain enable: 1 pulls the pad low |
| sys_rst | output | 1 | Merged system reset, active high |
| rst_cause | output | 6 | Sticky reset cause bits |
| gpio_mode | output | 1 | 1 = pad released for general-purpose use |

## Verification
The hardest case to reach is the echo of the block's own pulse on the pad. The filter then reports a low pad that must neither log an external cause nor release the reset early while the synchroniser catches up after the pad is let go. The bench models the pad as a wired-AND of the pull-low enable and an external driver. Each internal request therefore comes back through the real filter path, and the bench counts edges from the request to the pad release and on to the reset release. Separate scenarios hold the pad low externally for glitch-length and reset-length intervals, in both pad modes.

// File: rtl/reset_merge_pkg.sv
package reset_merge_pkg;
  localparam int NSRC      = 6;
  localparam int IDX_POR   = 0;
  localparam int IDX_PAD   = 1;
  localparam int IDX_IWDG  = 2;
  localparam int IDX_WWDG  = 3;
  localparam int IDX_DBG   = 4;
  localparam int IDX_BADOP = 5;
endpackage

// File: rtl/reset_merge_filt.sv
module reset_merge_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  output logic low_q,
  output logic low_evt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      cnt     <= '0;
      low_q   <= 1'b0;
      low_evt <= 1'b0;
    end else begin
      s1      <= pad_in;
      s2      <= s1;
      low_evt <= 1'b0;
      if (s2) begin
        cnt   <= '0;
        low_q <= 1'b0;
      end else if (!low_q) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          low_q   <= 1'b1;
          low_evt <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: filtered low only appears after a full run of low samples
  p_glitch_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(low_q) |-> (!$past(s2) && $past(cnt) == CW'(FILT_LEN - 1)));
  p_high_clears_r2: assert property (@(posedge clk) disable iff (rst)
    s2 |=> !low_q);
endmodule

// File: rtl/reset_merge_pulse.sv
module reset_merge_pulse #(
  parameter int PULSE_CYC = 2000
) (
  input  logic clk,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (trig)            cnt <= CW'(PULSE_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R4: any request reloads the full width
  p_retrig_r4: assert property (@(posedge clk)
    trig |=> cnt == CW'(PULSE_CYC));
  // R3: countdown never skips
  p_count_r3: assert property (@(posedge clk)
    (!trig && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/reset_merge_cause.sv
module reset_merge_cause
  import reset_merge_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] cause
);
  always_ff @(posedge clk) begin
    if (por) begin
      cause          <= '0;
      cause[IDX_POR] <= 1'b1;
    end else begin
      cause <= (cause & ~clr_vec) | set_vec;
    end
  end

  // R9: without a clear request no bit is ever lost
  p_sticky_r9: assert property (@(posedge clk) disable iff (por)
    (clr_vec == '0) |=> ((cause & $past(cause)) == $past(cause)));
  // R10: an active source always wins over a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (por)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/reset_merge.sv
module reset_merge
  import reset_merge_pkg::*;
#(
  parameter int PULSE_CYC = 2000,
  parameter int FILT_LEN  = 4
) (
  input  logic            clk,
  input  logic            src_por,
  input  logic            src_iwdg,
  input  logic            src_wwdg,
  input  logic            src_dbg,
  input  logic            src_badop,
  input  logic            pad_in,
  input  logic            gpio_wr,
  input  logic            gpio_val,
  input  logic [NSRC-1:0] cause_clr,
  output logic            pad_pull_low,
  output logic            sys_rst,
  output logic [NSRC-1:0] rst_cause,
  output logic            gpio_mode
);
  logic            int_any;
  logic            pulse_on;
  logic            pad_low_q;
  logic            pad_evt;
  logic            ext_hit;
  logic [NSRC-1:0] set_vec;

  assign int_any = src_por | src_iwdg | src_wwdg | src_dbg | src_badop;

  reset_merge_filt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst     (src_por),
    .pad_in  (pad_in),
    .low_q   (pad_low_q),
    .low_evt (pad_evt)
  );

  reset_merge_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk  (clk),
    .trig (int_any),
    .busy (pulse_on)
  );

  always_ff @(posedge clk) begin
    if (src_por)      gpio_mode <= 1'b0;
    else if (gpio_wr) gpio_mode <= gpio_val;
  end

  assign ext_hit = pad_low_q & ~gpio_mode;

  always_comb begin
    set_vec            = '0;
    set_vec[IDX_POR]   = src_por;
    set_vec[IDX_PAD]   = pad_evt & ~pulse_on & ~gpio_mode;
    set_vec[IDX_IWDG]  = src_iwdg;
    set_vec[IDX_WWDG]  = src_wwdg;
    set_vec[IDX_DBG]   = src_dbg;
    set_vec[IDX_BADOP] = src_badop;
  end

  reset_merge_cause u_cause (
    .clk     (clk),
    .por     (src_por),
    .set_vec (set_vec),
    .clr_vec (cause_clr),
    .cause   (rst_cause)
  );

  assign sys_rst      = int_any | pulse_on | ext_hit;
  assign pad_pull_low = pulse_on & ~gpio_mode;

  // R5: internal requests reach the reset without a clock
  p_async_r5: assert property (@(posedge clk) int_any |-> sys_rst);
  // R1: an internal request pulls the pad in pad-reset mode
  p_pull_r1: assert property (@(posedge clk) disable iff (src_por)
    int_any |=> (pad_pull_low || gpio_mode));
  // R7: reset still held right after power-on request drops
  p_por_hold_r7: assert property (@(posedge clk) disable iff (src_por)
    $fell(src_por) |-> pulse_on);
  // R8: pad ignored in general-purpose mode
  p_gpio_ignore_r8: assert property (@(posedge clk) disable iff (src_por)
    (gpio_mode && !int_any && !pulse_on) |-> !sys_rst);
endmodule

// File: tb/sim_reset_merge.sv
module sim_reset_merge;
  localparam int P = 32;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       src_por = 1'b1, src_iwdg = 1'b0, src_wwdg = 1'b0;
  logic       src_dbg = 1'b0, src_badop = 1'b0;
  logic       ext_low = 1'b0;
  logic       gpio_wr = 1'b0, gpio_val = 1'b0;
  logic [5:0] cause_clr = '0;
  logic       pad_in, pad_pull_low, sys_rst, gpio_mode;
  logic [5:0] rst_cause;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign pad_in = !(pad_pull_low | ext_low);

  reset_merge #(.PULSE_CYC(P), .FILT_LEN(N)) u0 (
    .clk(clk), .src_por(src_por), .src_iwdg(src_iwdg), .src_wwdg(src_wwdg),
    .src_dbg(src_dbg), .src_badop(src_badop), .pad_in(pad_in),
    .gpio_wr(gpio_wr), .gpio_val(gpio_val), .cause_clr(cause_clr),
    .pad_pull_low(pad_pull_low), .sys_rst(sys_rst), .rst_cause(rst_cause),
    .gpio_mode(gpio_mode)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (sys_rst && n < 500) begin tick(); n++; end
  endtask

  task automatic clear_all();
    cause_clr = 6'b111111; tick(); cause_clr = '0;
  endtask

  task automatic t_por();
    int n;
    bit held;
    src_por = 1'b1;
    repeat (3) tick();
    check(sys_rst == 1'b1, "R7 reset during por", sys_rst, 1);
    check(pad_pull_low == 1'b1, "R1 pad pulled during por", pad_pull_low, 1);
    held = 1'b1;
    for (int i = 0; i < P + 8; i++) begin tick(); if (!sys_rst) held = 1'b0; end
    check(held, "R7 long por hold", held, 1);
    src_por = 1'b0;
    wait_release(n);
    check(n == P + 3, "R6 release after por", n, P + 3);
    check(rst_cause == 6'b000001, "R9 por cause value", rst_cause, 1);
    check(gpio_mode == 1'b0, "R8 por clears mode", gpio_mode, 0);
  endtask

  task automatic t_wdog();
    int n;
    clear_all();
    src_iwdg = 1'b1;
    #1;
    check(sys_rst == 1'b1, "R5 async assert", sys_rst, 1);
    tick();
    check(pad_pull_low == 1'b1, "R1 pad pulled by watchdog", pad_pull_low, 1);
    src_iwdg = 1'b0;
    n = 0;
    while (pad_pull_low && n < 500) begin tick(); n++; end
    check(n == P, "R3 pulse width", n, P);
    while (sys_rst && n < 500) begin tick(); n++; end
    check(n == P + 3, "R6 release after pad high", n, P + 3);
    check(rst_cause == 6'b000100, "R9 watchdog cause", rst_cause, 4);
    check(rst_cause[1] == 1'b0, "R11 no pad cause from echo", rst_cause[1], 0);
  endtask

  task automatic t_retrig();
    int n;
    src_wwdg = 1'b1; tick(); src_wwdg = 1'b0;
    repeat (10) tick();
    check(pad_pull_low == 1'b1, "R4 pulse active", pad_pull_low, 1);
    src_wwdg = 1'b1; tick(); src_wwdg = 1'b0;
    n = 0;
    while (pad_pull_low && n < 500) begin tick(); n++; end
    check(n == P, "R4 restart from retrigger", n, P);
    wait_release(n);
    check(rst_cause == 6'b001100, "R9 sticky bits", rst_cause, 12);
  endtask

  task automatic t_clear();
    int n;
    cause_clr = 6'b001000; tick(); cause_clr = '0;
    check(rst_cause == 6'b000100, "R10 single bit clear", rst_cause, 4);
    src_dbg = 1'b1; cause_clr = 6'b010000; tick();
    src_dbg = 1'b0; cause_clr = '0;
    check(rst_cause[4] == 1'b1, "R10 set beats clear", rst_cause[4], 1);
    wait_release(n);
  endtask

  task automatic t_glitch();
    int n;
    bit quiet;
    clear_all();
    ext_low = 1'b1; repeat (3) tick(); ext_low = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 10; i++) begin tick(); if (sys_rst) quiet = 1'b0; end
    check(quiet, "R2 glitch ignored", quiet, 1);
    check(rst_cause == 6'b000000, "R2 no cause from glitch", rst_cause, 0);
    ext_low = 1'b1;
    n = 0;
    while (!sys_rst && n < 20) begin tick(); n++; end
    check(n == 6, "R2 filter latency", n, 6);
    check(pad_pull_low == 1'b0, "R1 no drive on external reset", pad_pull_low, 0);
    tick();
    check(rst_cause == 6'b000010, "R2 pad cause", rst_cause, 2);
    ext_low = 1'b0;
    wait_release(n);
    check(n == 3, "R6 external release", n, 3);
  endtask

  task automatic t_gpio();
    int n;
    bit quiet;
    clear_all();
    gpio_val = 1'b1; gpio_wr = 1'b1; tick(); gpio_wr = 1'b0; gpio_val = 1'b0;
    check(gpio_mode == 1'b1, "R8 mode write", gpio_mode, 1);
    ext_low = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin tick(); if (sys_rst) quiet = 1'b0; end
    ext_low = 1'b0;
    check(quiet, "R8 pad ignored", quiet, 1);
    check(rst_cause[1] == 1'b0, "R8 no pad cause", rst_cause[1], 0);
    src_badop = 1'b1; tick(); src_badop = 1'b0;
    check(pad_pull_low == 1'b0, "R8 no pad drive", pad_pull_low, 0);
    wait_release(n);
    check(n == P, "R6 release in gpio mode", n, P);
    check(rst_cause == 6'b100000, "R9 opcode cause", rst_cause, 32);
    check(gpio_mode == 1'b1, "R8 mode survives reset", gpio_mode, 1);
  endtask

  initial begin
    t_por();
    t_wdog();
    t_retrig();
    t_clear();
    t_glitch();
    t_gpio();
    t_por();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule